// File: doc/BRIEF.md
# Real-Time Clock Register Bank

This block is the register file of a real-time clock. It keeps a packed calendar date word, a packed time-of-day word, a read-only control word and a set of general-purpose scratch words. Software reaches all of them over a simple 32-bit register bus made of a select, a write strobe, a byte address, write data and read data. It does not count seconds. The date and time words hold whatever was last loaded, and software reads them back unchanged.

When software writes the date or the time word, a sticky "update pending" flag is raised in the control word. The next read of the control word returns the flags and clears them in that same access. Each flag therefore reports one write, and only the first read that follows it sees the flag. At reset the bank clears itself. If the base-year parameter is above 1900, the bank then loads date and time from static strap inputs, storing the year as an offset from the base year.

The bus accepts one access per cycle and applies no back-pressure. A write takes effect at the clock edge that ends its cycle. Read data is registered and is valid in the cycle after the read. Between reads it holds its last value.

Top module: `rtc_regbank`

## Requirements
- R1: After reset the control word and every scratch word read as zero.
- R2: With the base year above 1900, the date word after reset reads {full year minus base year in bits 31:16, month in bits 15:8, day in bits 7:0}. The time word reads {weekday in bits 31:29, Monday = 0 through Sunday = 6, zero in bits 28:24, hour in bits 23:16, minute in bits 15:8, second in bits 7:0}.
- R3: A write to offset 0x010 stores the full word as the date and sets bit 7 of the control word (offset 0x000).
- R4: A write to offset 0x014 stores the full word as the time and sets bit 8 of the control word.
- R5: A read of the control word returns the flags as they stood, in the read data of the next cycle. It clears both flags, so an immediately following read returns zero.
- R6: Scratch word k lives at offset 0x100 + 4k (k = 0..7). It reads back what was last written to it, and accessing it never changes the control flags.
- R7: A read at a misaligned address (bits 1:0 nonzero), at an unmapped offset inside the 0x000–0x3FF window, or at or above 0x400 returns zero.
- R8: A write to the control word, to an unmapped or misaligned address, or to an address at or above 0x400 changes no register.
- R9: Only full 32-bit word accesses exist. No byte lanes are decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_year | input | 16 | Full calendar year loaded at reset |
| strap_month | input | 8 | Month 1–12 loaded at reset |
| strap_day | input | 8 | Day of month loaded at reset |
| strap_wday | input | 3 | Weekday loaded at reset, Monday = 0 |
| strap_hour | input | 8 | Hour loaded at reset |
| strap_min | input | 8 | Minute loaded at reset |
| strap_sec | input | 8 | Second loaded at reset |
| bus_sel | input | 1 | Access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |

## Verification
Two events meet at the same register boundary: a date or time write raises a flag at the edge that ends its cycle, and a control read in the very next cycle must capture that flag and clear it at its own edge. The bench issues the write and the control read back to back with no idle cycle between them. It expects the flag bit in the read data and then a zero from a second control read right after. It also writes both date and time before a single control read, and expects both bits in one read and both cleared afterwards.

// File: rtl/rtc_regbank_pkg.sv
package rtc_regbank_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned WIDX_W      = 8;
  localparam int unsigned IDX_CTRL    = 0;
  localparam int unsigned IDX_DATE    = 4;
  localparam int unsigned IDX_TIME    = 5;
  localparam int unsigned IDX_GP_BASE = 64;
  localparam int unsigned BIT_DATE_UPD = 7;
  localparam int unsigned BIT_TIME_UPD = 8;

  typedef enum logic [2:0] {
    RS_NONE, RS_CTRL, RS_DATE, RS_TIME, RS_GP
  } regsel_e;

  function automatic logic [WORD_W-1:0] pack_date(
      input logic [15:0] yoff, input logic [7:0] mon, input logic [7:0] day);
    return {yoff, mon, day};
  endfunction

  function automatic logic [WORD_W-1:0] pack_time(
      input logic [2:0] wday, input logic [7:0] hr,
      input logic [7:0] mn, input logic [7:0] sc);
    return {wday, 5'b0, hr, mn, sc};
  endfunction
endpackage

// File: rtl/rtc_addr_decode.sv
module rtc_addr_decode
  import rtc_regbank_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned GP_COUNT = 8,
  localparam int unsigned GP_IDX_W = (GP_COUNT > 1) ? $clog2(GP_COUNT) : 1
) (
  input  logic [ADDR_W-1:0]   addr,
  output regsel_e             rsel,
  output logic [GP_IDX_W-1:0] gp_idx
);
  logic              in_window;
  logic [WIDX_W-1:0] widx;
  logic [WIDX_W-1:0] gp_off;

  generate
    if (ADDR_W > 10) begin : g_upper
      assign in_window = (addr[ADDR_W-1:10] == '0);
    end else begin : g_noupper
      assign in_window = 1'b1;
    end
  endgenerate

  assign widx   = addr[9:2];
  assign gp_off = widx - WIDX_W'(IDX_GP_BASE);
  assign gp_idx = gp_off[GP_IDX_W-1:0];

  always_comb begin
    rsel = RS_NONE;
    if (in_window && addr[1:0] == 2'b00) begin
      if (widx == WIDX_W'(IDX_CTRL))      rsel = RS_CTRL;
      else if (widx == WIDX_W'(IDX_DATE)) rsel = RS_DATE;
      else if (widx == WIDX_W'(IDX_TIME)) rsel = RS_TIME;
      else if (widx >= WIDX_W'(IDX_GP_BASE) &&
               gp_off < WIDX_W'(GP_COUNT)) rsel = RS_GP;
    end
  end
endmodule

// File: rtl/rtc_scratch_file.sv
module rtc_scratch_file
  import rtc_regbank_pkg::*;
#(
  parameter int unsigned GP_COUNT = 8,
  localparam int unsigned GP_IDX_W = (GP_COUNT > 1) ? $clog2(GP_COUNT) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [GP_IDX_W-1:0]        idx,
  input  logic [WORD_W-1:0]          wdata,
  output logic [GP_COUNT*WORD_W-1:0] words
);
  generate
    for (genvar k = 0; k < GP_COUNT; k++) begin : g_word
      always_ff @(posedge clk) begin
        if (!rst_n)
          words[k*WORD_W +: WORD_W] <= '0;
        else if (we && idx == GP_IDX_W'(k))
          words[k*WORD_W +: WORD_W] <= wdata;
      end
    end
  endgenerate
endmodule

// File: rtl/rtc_datetime_regs.sv
module rtc_datetime_regs
  import rtc_regbank_pkg::*;
#(
  parameter int BASE_YEAR = 1970
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       strap_year,
  input  logic [7:0]        strap_month,
  input  logic [7:0]        strap_day,
  input  logic [2:0]        strap_wday,
  input  logic [7:0]        strap_hour,
  input  logic [7:0]        strap_min,
  input  logic [7:0]        strap_sec,
  input  logic              we_date,
  input  logic              we_time,
  input  logic              rd_ctrl,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] date_q,
  output logic [WORD_W-1:0] time_q,
  output logic              flag_date,
  output logic              flag_time
);
  logic [WORD_W-1:0] date_rst, time_rst;

  generate
    if (BASE_YEAR > 1900) begin : g_load
      assign date_rst = pack_date(strap_year - 16'(BASE_YEAR), strap_month, strap_day);
      assign time_rst = pack_time(strap_wday, strap_hour, strap_min, strap_sec);
    end else begin : g_zero
      assign date_rst = '0;
      assign time_rst = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      date_q <= date_rst;
      time_q <= time_rst;
    end else begin
      if (we_date) date_q <= wdata;
      if (we_time) time_q <= wdata;
    end
  end

  // A set in the same cycle as a clearing read wins.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_date <= 1'b0;
      flag_time <= 1'b0;
    end else begin
      flag_date <= we_date | (flag_date & ~rd_ctrl);
      flag_time <= we_time | (flag_time & ~rd_ctrl);
    end
  end
endmodule

// File: rtl/rtc_regbank.sv
module rtc_regbank
  import rtc_regbank_pkg::*;
#(
  parameter int          BASE_YEAR = 1970,
  parameter int unsigned GP_COUNT  = 8,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       strap_year,
  input  logic [7:0]        strap_month,
  input  logic [7:0]        strap_day,
  input  logic [2:0]        strap_wday,
  input  logic [7:0]        strap_hour,
  input  logic [7:0]        strap_min,
  input  logic [7:0]        strap_sec,
  input  logic              bus_sel,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  localparam int unsigned GP_IDX_W = (GP_COUNT > 1) ? $clog2(GP_COUNT) : 1;

  regsel_e                   rsel;
  logic [GP_IDX_W-1:0]       gp_idx;
  logic [GP_COUNT*WORD_W-1:0] gp_words;
  logic [WORD_W-1:0]         date_q, time_q, ctrl_val, rd_mux;
  logic                      flag_date, flag_time;
  logic                      wr_acc, rd_acc;

  assign wr_acc = bus_sel &  bus_write;
  assign rd_acc = bus_sel & ~bus_write;

  rtc_addr_decode #(.ADDR_W(ADDR_W), .GP_COUNT(GP_COUNT)) u_dec (
    .addr(bus_addr), .rsel(rsel), .gp_idx(gp_idx)
  );

  rtc_scratch_file #(.GP_COUNT(GP_COUNT)) u_gp (
    .clk(clk), .rst_n(rst_n),
    .we(wr_acc && rsel == RS_GP), .idx(gp_idx),
    .wdata(bus_wdata), .words(gp_words)
  );

  rtc_datetime_regs #(.BASE_YEAR(BASE_YEAR)) u_dt (
    .clk(clk), .rst_n(rst_n),
    .strap_year(strap_year), .strap_month(strap_month), .strap_day(strap_day),
    .strap_wday(strap_wday), .strap_hour(strap_hour), .strap_min(strap_min),
    .strap_sec(strap_sec),
    .we_date(wr_acc && rsel == RS_DATE),
    .we_time(wr_acc && rsel == RS_TIME),
    .rd_ctrl(rd_acc && rsel == RS_CTRL),
    .wdata(bus_wdata),
    .date_q(date_q), .time_q(time_q),
    .flag_date(flag_date), .flag_time(flag_time)
  );

  always_comb begin
    ctrl_val = '0;
    ctrl_val[BIT_DATE_UPD] = flag_date;
    ctrl_val[BIT_TIME_UPD] = flag_time;
  end

  always_comb begin
    unique case (rsel)
      RS_CTRL: rd_mux = ctrl_val;
      RS_DATE: rd_mux = date_q;
      RS_TIME: rd_mux = time_q;
      RS_GP:   rd_mux = gp_words[gp_idx*WORD_W +: WORD_W];
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_acc) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/rtc_regbank_chk.sv
module rtc_regbank_chk #(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_rdata,
  input logic              flag_date,
  input logic              flag_time
);
  logic wr, rd;
  assign wr = bus_sel && bus_write;
  assign rd = bus_sel && !bus_write;

  assert_date_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == ADDR_W'('h010)) |=> flag_date);

  assert_time_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == ADDR_W'('h014)) |=> flag_time);

  assert_ctrl_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr == '0) |=> (!flag_date && !flag_time));

  assert_ctrl_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr == '0) |=>
      (bus_rdata[7] == $past(flag_date) && bus_rdata[8] == $past(flag_time)));

  assert_gp_no_side_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_addr[ADDR_W-1:8] == 1) |=>
      (flag_date == $past(flag_date) && flag_time == $past(flag_time)));

  assert_misaligned_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && bus_addr[1:0] != 2'b00) |=> (bus_rdata == '0));

  assert_ctrl_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && bus_addr == '0) |=>
      (flag_date == $past(flag_date) && flag_time == $past(flag_time)));
endmodule

bind rtc_regbank rtc_regbank_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .flag_date(flag_date), .flag_time(flag_time)
);

// File: tb/sim_rtc_regbank.sv
module sim_rtc_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int n_tests = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  rtc_regbank #(.BASE_YEAR(1970), .GP_COUNT(8), .ADDR_W(12)) u0 (
    .clk(clk), .rst_n(rst_n),
    .strap_year(16'd2024), .strap_month(8'd3), .strap_day(8'd15),
    .strap_wday(3'd4), .strap_hour(8'd13), .strap_min(8'd45), .strap_sec(8'd30),
    .bus_sel(bus_sel), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // Driver tasks: one access per cycle, driven at the falling edge.
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
  endtask

  task automatic idle();
    @(negedge clk);
    bus_sel = 1'b0; bus_write = 1'b0;
  endtask

  // Monitor: a read seen at an edge has its data one time unit later.
  always @(posedge clk) begin
    logic was_rd;
    was_rd = rst_n && bus_sel && !bus_write;
    #1;
    if (was_rd) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_tests++;
      if (bus_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: got %h expected %h", t, bus_rdata, e);
      end
    end
  end

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 / R2 reset state
    rd(12'h000, 32'h0000_0000, "R1 ctrl after reset");
    rd(12'h11C, 32'h0000_0000, "R1 scratch7 after reset");
    rd(12'h010, 32'h0036_030F, "R2 date strap load");
    rd(12'h014, 32'h800D_2D1E, "R2 time strap load");
    // R3: date write then immediate control read
    wr(12'h010, 32'h0012_0C1F);
    rd(12'h000, 32'h0000_0080, "R3 date flag");
    rd(12'h000, 32'h0000_0000, "R5 second ctrl read");
    rd(12'h010, 32'h0012_0C1F, "R3 date stored");
    // R4
    wr(12'h014, 32'hC017_2A05);
    rd(12'h000, 32'h0000_0100, "R4 time flag");
    rd(12'h014, 32'hC017_2A05, "R4 time stored");
    // R5 both flags
    wr(12'h010, 32'h0001_0101);
    wr(12'h014, 32'h0001_0203);
    rd(12'h000, 32'h0000_0180, "R5 both flags");
    rd(12'h000, 32'h0000_0000, "R5 both cleared");
    // R6 scratch words
    for (int k = 0; k < 8; k++) wr(12'(12'h100 + 4*k), 32'hA5A5_0000 ^ (32'h1111_1111 * k));
    for (int k = 0; k < 8; k++)
      rd(12'(12'h100 + 4*k), 32'hA5A5_0000 ^ (32'h1111_1111 * k), "R6 scratch readback");
    rd(12'h000, 32'h0000_0000, "R6 no flag side effect");
    // R7 zero reads
    rd(12'h008, 32'h0, "R7 unmapped offset");
    rd(12'h0FC, 32'h0, "R7 below scratch");
    rd(12'h120, 32'h0, "R7 past scratch7");
    rd(12'h102, 32'h0, "R7 misaligned");
    rd(12'h400, 32'h0, "R7 beyond window");
    rd(12'h011, 32'h0, "R9 byte address into date");
    // R8 writes with no effect
    wr(12'h500, 32'hDEAD_BEEF);
    wr(12'h105, 32'h1234_5678);
    wr(12'h011, 32'hFFFF_FFFF);
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'h008, 32'h5555_5555);
    rd(12'h100, 32'hA5A5_0000, "R8 aliased write ignored");
    rd(12'h104, 32'hB4B4_1111, "R8 misaligned write ignored");
    rd(12'h010, 32'h0001_0101, "R8 date untouched");
    rd(12'h000, 32'h0000_0000, "R8 ctrl write ignored");
    rd(12'h008, 32'h0, "R8 unmapped write ignored");
    idle();
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule